// File: doc/BRIEF.md
# Identification packet line and payload capture window

This block sits in the transmit path of a standard-definition serial digital video link, in front of the logic that builds and inserts the video identification packet into the horizontal ancillary space. On each video line the packet needs a line number and four 10-bit user payload words. The upstream logic presents them live. This block samples them at one defined point and presents a stable copy to the packet builder.

The sample point is the strobe cycle that carries the last word of the end-of-active-video sequence. The held copy stays fixed until the next capture. A window flag marks the interval in which the copy is in use. It opens at capture and closes on the first word of the following start-of-active-video sequence, which bounds the horizontal ancillary interval. Inside the window, the block compares the live inputs against the held copy on every word strobe. Any mismatch raises a sticky violation flag, which tells the integrator that the upstream timing contract was broken.

The line number matters only when packet insertion is enabled. When insertion is off, the line number is neither captured nor compared.

Top module: `sdi_id_capture`

## Requirements
- R1: On a rising clock edge with `ce_i` and `eav_i` both high, the four payload words are captured and appear on `pay_o` after that edge.
- R2: The line number is captured on a capture strobe only if `ins_en_i` is high in that cycle. Otherwise `line_o` keeps its previous value.
- R3: `pay_o` and `line_o` change only on a capture strobe. Input changes at any other time have no effect on them.
- R4: `win_o` goes high after every capture strobe.
- R5: While the window is open, a strobe with `sav_i` high and `eav_i` low closes it. `sav_i` without `ce_i` has no effect. When `eav_i` and `sav_i` share one strobe, capture wins and the window is open afterwards.
- R6: `viol_o` is set after a strobe on which all of the following hold:
  - the window is open;
  - the strobe is neither a capture nor the closing start-of-active word;
  - `pay_i` differs from the held payload, or `ins_en_i` is high and `line_i` differs from the held line.

  Changes without a strobe, and line differences while `ins_en_i` is low, do not set `viol_o`.
- R7: `viol_o` stays high until reset. An active-low asynchronous reset clears `win_o`, `viol_o`, `line_o` and `pay_o` to zero.
- R8: Payload word k (k = 0..3) occupies bits [10k+9:10k] of `pay_i` and `pay_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Word strobe; a word is valid when high |
| eav_i | input | 1 | Last word of the end-of-active-video sequence |
| sav_i | input | 1 | First word of the start-of-active-video sequence |
| ins_en_i | input | 1 | Packet insertion enable; gates line capture and line compare |
| line_i | input | 11 | Live line number |
| pay_i | input | 40 | Four live payload words, word k at [10k+9:10k] |
| line_o | output | 11 | Held line number |
| pay_o | output | 40 | Held payload words |
| win_o | output | 1 | Hold window active |
| viol_o | output | 1 | Sticky input-change-in-window flag |

## Verification
A window flag stuck open, or one that fails to open, shows in two ways at the ports:
- at once on `win_o`, one edge after the capture or closing strobe;
- on `viol_o`, which then fires on payload changes after the start-of-active word or stays silent inside the horizontal ancillary interval.

A lost or misplaced capture shows on `pay_o` and `line_o` one edge after the strobe that carries the end-of-active word. A broken compare, or a violation flag that fails to hold, shows on `viol_o` one edge after the offending strobe, or on the next clean strobe after it.

// File: rtl/sdi_cap_pkg.sv
package sdi_cap_pkg;
  localparam int WORD_W  = 10;
  localparam int LINE_W  = 11;
  localparam int N_WORDS = 4;
  localparam int PAY_W   = WORD_W * N_WORDS;

  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_OPEN = 1'b1
  } win_state_e;
endpackage

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import sdi_cap_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic eav_i,
  input  logic sav_i,
  output logic cap_o,
  output logic chk_o,
  output logic open_o
);
  win_state_e state_q, state_d;

  assign cap_o  = ce_i & eav_i;
  assign open_o = (state_q == WIN_OPEN);
  // compare only on plain words inside the window
  assign chk_o  = ce_i & open_o & ~eav_i & ~sav_i;

  always_comb begin
    state_d = state_q;
    if (cap_o)                    state_d = WIN_OPEN;
    else if (ce_i && sav_i && open_o) state_d = WIN_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= WIN_IDLE;
    else         state_q <= state_d;
  end

  AST_WIN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && eav_i) |=> open_o); // R4
  AST_WIN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && sav_i && !eav_i) |=> !open_o); // R5
  AST_WIN_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable(open_o)); // R5
endmodule

// File: rtl/cap_regs.sv
module cap_regs #(
  parameter int WORD_W  = 10,
  parameter int LINE_W  = 11,
  parameter int N_WORDS = 4,
  localparam int PAY_W  = WORD_W * N_WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              line_en_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [PAY_W-1:0]  pay_i,
  output logic [LINE_W-1:0] line_q,
  output logic [PAY_W-1:0]  pay_q
);
  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    pay_q[k*WORD_W +: WORD_W] <= '0;
      else if (cap_i) pay_q[k*WORD_W +: WORD_W] <= pay_i[k*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  line_q <= '0;
    else if (cap_i && line_en_i)  line_q <= line_i;
  end

  AST_PAY_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (pay_q == $past(pay_i))); // R1
  AST_PAY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(pay_q)); // R3
  AST_LINE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cap_i && line_en_i) |=> $stable(line_q)); // R2
endmodule

// File: rtl/cap_mon.sv
module cap_mon #(
  parameter int WORD_W  = 10,
  parameter int LINE_W  = 11,
  parameter int N_WORDS = 4,
  localparam int PAY_W  = WORD_W * N_WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chk_i,
  input  logic              line_en_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [LINE_W-1:0] line_q,
  input  logic [PAY_W-1:0]  pay_i,
  input  logic [PAY_W-1:0]  pay_q,
  output logic              viol_o
);
  logic [N_WORDS-1:0] word_diff;
  logic               line_diff;
  logic               viol_q;

  for (genvar k = 0; k < N_WORDS; k++) begin : g_cmp
    assign word_diff[k] = (pay_i[k*WORD_W +: WORD_W] != pay_q[k*WORD_W +: WORD_W]);
  end
  assign line_diff = line_en_i & (line_i != line_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  viol_q <= 1'b0;
    else if (chk_i && (|word_diff || line_diff))  viol_q <= 1'b1;
  end
  assign viol_o = viol_q;

  AST_VIOL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_q |=> viol_q); // R7
  AST_VIOL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_i |=> $stable(viol_q)); // R6
endmodule

// File: rtl/sdi_id_capture.sv
module sdi_id_capture
  import sdi_cap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              eav_i,
  input  logic              sav_i,
  input  logic              ins_en_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [PAY_W-1:0]  pay_i,
  output logic [LINE_W-1:0] line_o,
  output logic [PAY_W-1:0]  pay_o,
  output logic              win_o,
  output logic              viol_o
);
  logic cap, chk;

  cap_ctrl u_ctrl (
    .clk_i, .rst_ni, .ce_i, .eav_i, .sav_i,
    .cap_o(cap), .chk_o(chk), .open_o(win_o)
  );

  cap_regs #(.WORD_W(WORD_W), .LINE_W(LINE_W), .N_WORDS(N_WORDS)) u_regs (
    .clk_i, .rst_ni, .cap_i(cap), .line_en_i(ins_en_i),
    .line_i, .pay_i, .line_q(line_o), .pay_q(pay_o)
  );

  cap_mon #(.WORD_W(WORD_W), .LINE_W(LINE_W), .N_WORDS(N_WORDS)) u_mon (
    .clk_i, .rst_ni, .chk_i(chk), .line_en_i(ins_en_i),
    .line_i, .line_q(line_o), .pay_i, .pay_q(pay_o), .viol_o
  );

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (!win_o && !viol_o)); // R7
endmodule

// File: tb/sim_sdi_id_capture.sv
module sim_sdi_id_capture;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce_i = 1'b0, eav_i = 1'b0, sav_i = 1'b0, ins_en_i = 1'b0;
  logic [10:0] line_i = '0;
  logic [39:0] pay_i = '0;
  logic [10:0] line_o;
  logic [39:0] pay_o;
  logic        win_o, viol_o;

  int errors = 0;
  int checks = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  sdi_id_capture u0 (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, one posedge passes, back at negedge for sampling
  task automatic step(input logic ce, input logic eav, input logic sav);
    ce_i = ce; eav_i = eav; sav_i = sav;
    @(negedge clk_i);
    ce_i = 1'b0; eav_i = 1'b0; sav_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    ins_en_i = 1'b1; line_i = '0; pay_i = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R7 win reset", win_o, 0);
    chk("R7 viol reset", viol_o, 0);
    chk("R7 pay reset", pay_o, 0);
    chk("R7 line reset", line_o, 0);
  endtask

  task automatic t_capture();
    do_reset();
    ins_en_i = 1'b1; line_i = 11'h3A5;
    pay_i = {10'h3C1, 10'h2B2, 10'h1A3, 10'h094};
    step(1, 1, 0);
    chk("R1 pay capture", pay_o, {10'h3C1, 10'h2B2, 10'h1A3, 10'h094});
    chk("R8 word2 slice", pay_o[29:20], 10'h2B2);
    chk("R2 line capture", line_o, 11'h3A5);
    chk("R4 window open", win_o, 1);
    // R3: change without strobe ignored
    pay_i = '1; line_i = 11'h7FF;
    step(0, 0, 0);
    chk("R3 pay hold", pay_o, {10'h3C1, 10'h2B2, 10'h1A3, 10'h094});
    chk("R3 line hold", line_o, 11'h3A5);
    chk("R6 no strobe no viol", viol_o, 0);
    // eav without strobe does not capture
    step(0, 1, 0);
    chk("R3 eav without strobe", pay_o[9:0], 10'h094);
  endtask

  task automatic t_violation();
    do_reset();
    pay_i = {4{10'h155}}; line_i = 11'd20;
    step(1, 1, 0);
    step(1, 0, 0);
    chk("R6 clean strobe", viol_o, 0);
    pay_i[19:10] = 10'h0AA;
    step(1, 0, 0);
    chk("R6 pay change flagged", viol_o, 1);
    pay_i = {4{10'h155}};
    step(1, 0, 0);
    chk("R7 viol sticky", viol_o, 1);
    do_reset();
    chk("R7 viol cleared", viol_o, 0);
    // line compare with insertion enabled
    line_i = 11'd30;
    step(1, 1, 0);
    line_i = 11'd31;
    step(1, 0, 0);
    chk("R6 line change flagged", viol_o, 1);
  endtask

  task automatic t_line_gate();
    do_reset();
    ins_en_i = 1'b0; line_i = 11'd5; pay_i = 40'h12345;
    step(1, 1, 0);
    chk("R2 line not captured", line_o, 0);
    chk("R1 pay captured", pay_o, 40'h12345);
    line_i = 11'd99;
    step(1, 0, 0);
    chk("R6 line ignored when disabled", viol_o, 0);
  endtask

  task automatic t_sav();
    do_reset();
    pay_i = 40'hABCDE;
    step(1, 1, 0);
    step(0, 0, 1);
    chk("R5 sav without strobe", win_o, 1);
    pay_i = 40'h11111;
    step(1, 0, 1);
    chk("R5 window closed", win_o, 0);
    chk("R6 closing word not compared", viol_o, 0);
    step(1, 0, 0);
    chk("R6 outside window", viol_o, 0);
    step(1, 1, 1);
    chk("R5 eav beats sav", win_o, 1);
    chk("R1 recapture", pay_o, 40'h11111);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_capture();
        t_violation();
        t_line_gate();
        t_sav();
      end
      begin
        repeat (5000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule